// File: doc/BRIEF.md
# Embedded Operation Toggle Status Generator

This block produces the toggle-type status bit that a flash-style device places on data line 6 while a status read is in progress. While an internal program or erase runs, every new read cycle inverts the bit. A host polls the line twice and compares the results: a changed value means the operation is still running, and an unchanged one means it has finished. Reading stops toggling when the operation completes or when an erase is suspended. The bit toggles again during a program issued while the erase is suspended.

A command can target protected sectors. A program to a protected address, or an erase whose selected sectors are all protected, makes no change to the array. The block then runs a timed stand-in window so that the host still sees a short busy period. The window is counted on a one-microsecond tick. It lasts 100 ticks for an erase and 1000 ticks for a program, and afterwards the device reads array data again. A read cycle is the interval in which both output-enable and chip-enable are low. Only the start of a read cycle counts, so one of the two strobes must go high and then low again before a further toggle can occur.

Top module: `toggle_status_gen`

## Requirements
- R1: After reset, `toggle_bit` is 0 and `status_busy` is 0.
- R2: `op_state` encodings are 0 idle, 1 programming, 2 erasing, 3 erase-suspended and 4 program during erase suspend; values 5 to 7 behave as idle. In states 1, 2 and 4, `status_busy` is 1 and `toggle_bit` inverts once, on the clock edge that first samples a read start.
- R3: A read start is a cycle in which `oe_n` and `ce_n` are both low, following a cycle in which at least one of them was high. Keeping both low for further cycles causes no further inversion, and a cycle with only one strobe low is not a read.
- R4: In state 3, `status_busy` is 0 and `toggle_bit` keeps its value whatever reads occur.
- R5: When the device is neither busy nor in state 3, `toggle_bit` is 0 one clock after that condition is sampled, and reads do not change it.
- R6: A `cmd_done` pulse with `prot_hit`=1 and `cmd_erase`=1, sampled while idle, makes `status_busy` 1 from the next cycle. That window lasts exactly ERASE_US (default 100) sampled `us_tick` pulses, reads toggle the bit during it, and at its end `status_busy` falls and `toggle_bit` returns to 0.
- R7: A `cmd_done` pulse with `prot_hit`=1 and `cmd_erase`=0 opens the same kind of window, lasting PROG_US (default 1000) ticks.
- R8: A `cmd_done` pulse with `prot_hit`=0 opens no window, and `status_busy` stays 0.
- R9: A `cmd_done` pulse sampled while a window is open neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_state | input | 3 | Embedded operation state (encoding in R2) |
| cmd_done | input | 1 | One-cycle pulse at the end of a command sequence |
| prot_hit | input | 1 | Command targets only protected sectors |
| cmd_erase | input | 1 | Command is an erase (1) or a program (0) |
| oe_n | input | 1 | Output-enable, active low, synchronous to clk |
| ce_n | input | 1 | Chip-enable, active low, synchronous to clk |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| toggle_bit | output | 1 | Status bit for data line 6 |
| status_busy | output | 1 | Toggling is currently enabled |

## Verification
Several rules are checked by assertions on every cycle. While the block is busy, a read start inverts the bit, and with no read start the bit holds. In suspend the bit stays stable. Outside both states the bit is 0 a cycle later. An open window's counter stays below its limit, and a command arriving during a window leaves that window's length unchanged. Only the bench scenarios can show that a window lasts exactly 100 or 1000 ticks, that a single-strobe read or a held read does nothing, and that a command to unprotected sectors opens no window.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ESUSP  = 3'd3,
    OP_ESPROG = 3'd4
  } op_state_e;

  // Real embedded algorithm running: toggling enabled
  function automatic logic op_runs(input logic [2:0] s);
    return (s == OP_PROG) || (s == OP_ERASE) || (s == OP_ESPROG);
  endfunction

  function automatic logic op_suspended(input logic [2:0] s);
    return s == OP_ESUSP;
  endfunction

  // Length of a protected-sector stand-in window in microsecond ticks
  function automatic int unsigned win_len(input logic is_erase,
                                          input int unsigned erase_us,
                                          input int unsigned prog_us);
    return is_erase ? erase_us : prog_us;
  endfunction
endpackage

// File: rtl/tsg_read_detect.sv
module tsg_read_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic ce_n,
  output logic rd_start
);
  logic rd_now, rd_q;

  assign rd_now   = ~oe_n & ~ce_n;
  assign rd_start = rd_now & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_now;
  end

  // R3: two read starts are never back to back while the strobes stay low
  p_single_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
endmodule

// File: rtl/tsg_window_timer.sv
module tsg_window_timer #(
  parameter int unsigned ERASE_US = 100,
  parameter int unsigned PROG_US  = 1000,
  parameter int unsigned CW       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_erase,
  input  logic us_tick,
  output logic active
);
  import tsg_pkg::*;

  logic [CW-1:0] cnt, lim;
  logic          last_tick;

  assign last_tick = active & us_tick & (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      lim    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        lim    <= CW'(win_len(is_erase, ERASE_US, PROG_US));
      end
    end else if (last_tick) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (us_tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: count never reaches the window limit while open
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < lim));
  // R9: a start during an open window leaves its length untouched
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> $stable(lim));
endmodule

// File: rtl/tsg_toggle_reg.sv
module tsg_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hold,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (en) begin
      if (flip)          q <= ~q;
    end else if (!hold)  q <= 1'b0;
  end

  // R2: a qualified read while enabled inverts the bit
  p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flip) |=> (q != $past(q)));
  // R3: without a read start the bit keeps its value while active or held
  p_hold_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && (en || hold)) |=> $stable(q));
  // R4: suspended, the bit is frozen
  p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !en) |=> $stable(q));
  // R5: neither active nor held forces zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hold) |=> (q == 1'b0));
endmodule

// File: rtl/toggle_status_gen.sv
module toggle_status_gen #(
  parameter int unsigned ERASE_US = 100,
  parameter int unsigned PROG_US  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_state,
  input  logic       cmd_done,
  input  logic       prot_hit,
  input  logic       cmd_erase,
  input  logic       oe_n,
  input  logic       ce_n,
  input  logic       us_tick,
  output logic       toggle_bit,
  output logic       status_busy
);
  import tsg_pkg::*;

  localparam int unsigned MAX_US = (PROG_US > ERASE_US) ? PROG_US : ERASE_US;
  localparam int unsigned CW     = $clog2(MAX_US + 1);

  logic rd_start, win_active, real_run, susp, win_start;

  assign real_run    = op_runs(op_state);
  assign susp        = op_suspended(op_state);
  assign win_start   = cmd_done & prot_hit & ~real_run & ~susp;
  assign status_busy = real_run | win_active;

  tsg_read_detect u_rd (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .rd_start(rd_start)
  );

  tsg_window_timer #(.ERASE_US(ERASE_US), .PROG_US(PROG_US), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .start(win_start), .is_erase(cmd_erase),
    .us_tick(us_tick), .active(win_active)
  );

  tsg_toggle_reg u_tgl (
    .clk(clk), .rst_n(rst_n), .en(status_busy), .hold(susp & ~win_active),
    .flip(rd_start), .q(toggle_bit)
  );

  // R8: an unprotected command never opens a window from idle
  p_no_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_active && cmd_done && !prot_hit) |=> !win_active);
endmodule

// File: tb/toggle_status_gen_bench.sv
module toggle_status_gen_bench;
  import tsg_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic cmd_done = 1'b0, prot_hit = 1'b0, cmd_erase = 1'b0;
  logic oe_n = 1'b1, ce_n = 1'b1, us_tick = 1'b0;
  logic toggle_bit, status_busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic exp_t = 1'b0;

  always #10 clk = ~clk;

  toggle_status_gen u_toggle_status_gen (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .cmd_done(cmd_done),
    .prot_hit(prot_hit), .cmd_erase(cmd_erase), .oe_n(oe_n), .ce_n(ce_n),
    .us_tick(us_tick), .toggle_bit(toggle_bit), .status_busy(status_busy)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd();
    oe_n = 1'b0; ce_n = 1'b0;
    cyc(1);
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1; cyc(1);
    end
    us_tick = 1'b0;
  endtask

  task automatic cmd(input logic prot, input logic er);
    cmd_done = 1'b1; prot_hit = prot; cmd_erase = er;
    cyc(1);
    cmd_done = 1'b0; prot_hit = 1'b0; cmd_erase = 1'b0;
  endtask

  task automatic t_reset();
    chk(toggle_bit, 1'b0, "R1 toggle after reset");
    chk(status_busy, 1'b0, "R1 busy after reset");
  endtask

  task automatic t_idle_reads();
    rd(); rd();
    chk(toggle_bit, 1'b0, "R5 idle reads");
    op_state = 3'd6; cyc(1); rd();
    chk(status_busy, 1'b0, "R2 code 6 acts idle");
    chk(toggle_bit, 1'b0, "R5 code 6 reads");
    op_state = OP_IDLE; cyc(1);
  endtask

  task automatic t_program();
    op_state = OP_PROG; cyc(1);
    chk(status_busy, 1'b1, "R2 busy in program");
    rd(); exp_t = ~exp_t; chk(toggle_bit, exp_t, "R2 first read");
    rd(); exp_t = ~exp_t; chk(toggle_bit, exp_t, "R2 second read");
    oe_n = 1'b0; ce_n = 1'b0; cyc(4);
    exp_t = ~exp_t; chk(toggle_bit, exp_t, "R3 held read toggles once");
    ce_n = 1'b1; cyc(1); ce_n = 1'b0; cyc(1);
    exp_t = ~exp_t; chk(toggle_bit, exp_t, "R3 ce reassert toggles");
    oe_n = 1'b1; ce_n = 1'b1; cyc(1);
    oe_n = 1'b0; cyc(2); oe_n = 1'b1; cyc(1);
    chk(toggle_bit, exp_t, "R3 oe alone no read");
    op_state = OP_IDLE; cyc(2); exp_t = 1'b0;
    chk(toggle_bit, 1'b0, "R5 cleared after program");
  endtask

  task automatic t_suspend();
    op_state = OP_ERASE; cyc(1);
    rd(); exp_t = ~exp_t; chk(toggle_bit, exp_t, "R2 erase read");
    op_state = OP_ESUSP; cyc(1);
    chk(status_busy, 1'b0, "R4 busy in suspend");
    rd(); rd(); rd();
    chk(toggle_bit, exp_t, "R4 suspend holds");
    op_state = OP_ESPROG; cyc(1);
    rd(); exp_t = ~exp_t; chk(toggle_bit, exp_t, "R2 suspend-program read");
    rd(); exp_t = ~exp_t; chk(toggle_bit, exp_t, "R2 suspend-program read 2");
    op_state = OP_IDLE; cyc(2); exp_t = 1'b0;
    chk(toggle_bit, 1'b0, "R5 cleared after suspend-program");
  endtask

  task automatic t_erase_window();
    cmd(1'b1, 1'b1);
    chk(status_busy, 1'b1, "R6 window opens");
    rd(); chk(toggle_bit, 1'b1, "R6 window read toggles");
    ticks(99);
    chk(status_busy, 1'b1, "R6 busy after 99 ticks");
    ticks(1);
    chk(status_busy, 1'b0, "R6 closed at 100 ticks");
    cyc(1);
    chk(toggle_bit, 1'b0, "R6 bit zero after window");
  endtask

  task automatic t_prog_window();
    cmd(1'b1, 1'b0);
    chk(status_busy, 1'b1, "R7 window opens");
    ticks(500);
    cmd(1'b1, 1'b1);
    ticks(499);
    chk(status_busy, 1'b1, "R9 busy after 999 ticks");
    ticks(1);
    chk(status_busy, 1'b0, "R7 R9 closed at 1000 ticks");
    cyc(1);
  endtask

  task automatic t_unprot();
    cmd(1'b0, 1'b1); cyc(1);
    chk(status_busy, 1'b0, "R8 unprotected erase");
    cmd(1'b0, 1'b0); ticks(3); rd();
    chk(status_busy, 1'b0, "R8 unprotected program");
    chk(toggle_bit, 1'b0, "R8 no toggle");
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_idle_reads();
    t_program();
    t_suspend();
    t_erase_window();
    t_prog_window();
    t_unprot();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule